// File: doc/BRIEF.md
# Integer Execute Stage with Load-Data Extender

This block is the execute stage of a small load/store integer core. Each cycle it may accept one decoded operation, the two source operands already fetched from the register file together with their register indices, a 16-bit immediate, the destination index, and, for loads, the fetched memory word plus the low two bits of its address. On the following clock edge it presents a full 32-bit result, an overflow-trap flag and the register-write control (enable and destination) for the writeback stage.

Immediate extension depends on the class of the operation. Logical immediates are widened with zeros, arithmetic immediates with copies of their sign bit, and that includes the unsigned-named add-immediate. Only the signed add, signed subtract and signed add-immediate can raise the trap. When the trap is raised, the register write is withheld. Narrow loads pick their byte or halfword lane from the address, numbering lanes little-endian, and then widen the value with zeros or with its sign bit. Every operation drives all 32 result bits.

Top module: `int_exec_unit`

## Requirements
- R1: Immediates of the logical-immediate operations (op 10 ANDI, 11 ORI, 12 XORI) are widened with zeros to 32 bits before they are combined with operand A.
- R2: Immediates of the arithmetic-immediate operations (op 8 ADDI, 9 ADDIU) are sign-extended to 32 bits before they are added to operand A.
- R3: Operations other than op 0 ADD, op 2 SUB and op 8 ADDI never raise ovf_trap. This covers op 1 ADDU, 3 SUBU, the logical ops, the shifts, LUI and the loads.
- R4: ops 0 ADD, 2 SUB and 8 ADDI raise ovf_trap exactly when the true two's-complement result of A+B, A-B or A+sext(imm) does not fit in 32 signed bits. The result port still shows the wrapped 32-bit value.
- R5: When ovf_trap is high, wr_en is low for that operation.
- R6: Loads select their lane from ld_addr, numbering lanes little-endian. op 17 LB and op 18 LBU take byte ld_addr[1:0]. op 19 LH and op 20 LHU take halfword ld_addr[1]. op 21 LW takes the whole word. LBU and LHU widen with zeros, and LB and LH widen with the lane's top bit.
- R7: op 13 LUI yields {imm, 16'h0000}, whatever the value of operand A.
- R8: A destination index of 0 never produces wr_en. A source index (rs_idx, rt_idx) of 0 makes that operand read as zero, whatever its data input holds.
- R9: The register-register ops are 0 ADD, 1 ADDU, 2 SUB, 3 SUBU, 4 AND, 5 OR, 6 XOR and 7 NOR. The shifts are 14 SLL, 15 SRL and 16 SRA; each shifts operand A by imm[4:0], and SRA fills from the left with A[31]. All of these produce the full 32-bit result.
- R10: Outputs are registered with a latency of one cycle. out_valid follows in_valid. When out_valid is low, result, ovf_trap, wr_en and wr_dest are all zero. When out_valid is high, wr_dest is the captured dest_idx.
- R11: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 5 | Operation code (see requirements) |
| rs_idx | input | 5 | Register index of operand A |
| rt_idx | input | 5 | Register index of operand B |
| src_a | input | 32 | Operand A data |
| src_b | input | 32 | Operand B data |
| imm | input | 16 | Immediate field (also the shift amount, in bits 4:0) |
| dest_idx | input | 5 | Destination register index |
| ld_word | input | 32 | Memory word fetched for a load |
| ld_addr | input | 2 | Low address bits of the load |
| out_valid | output | 1 | Registered result is valid |
| result | output | 32 | 32-bit result |
| ovf_trap | output | 1 | Signed-overflow trap |
| wr_en | output | 1 | Register write enable |
| wr_dest | output | 5 | Register write index |

## Verification
The trap and the write to register 0 can both fall in a single cycle. Suppressing the write for the trap and suppressing it for destination 0 act on the same wr_en. The bench provokes this with a signed add that overflows into destination 0, and also with one that overflows into a live register. In both cases the reference model expects wr_en low and ovf_trap high. A zero source index combined with an immediate or shift operation is provoked in the same way, so that the read-as-zero rule and the extension rule apply in one cycle.

// File: rtl/iexu_pkg.sv
package iexu_pkg;
    localparam int XLEN   = 32;
    localparam int IMM_W  = 16;
    localparam int IDX_W  = 5;
    localparam int OP_W   = 5;
    localparam int SHAM_W = $clog2(XLEN);
    localparam int LANE_W = $clog2(XLEN / 8);

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_ADDU  = 5'd1,
        OP_SUB   = 5'd2,
        OP_SUBU  = 5'd3,
        OP_AND   = 5'd4,
        OP_OR    = 5'd5,
        OP_XOR   = 5'd6,
        OP_NOR   = 5'd7,
        OP_ADDI  = 5'd8,
        OP_ADDIU = 5'd9,
        OP_ANDI  = 5'd10,
        OP_ORI   = 5'd11,
        OP_XORI  = 5'd12,
        OP_LUI   = 5'd13,
        OP_SLL   = 5'd14,
        OP_SRL   = 5'd15,
        OP_SRA   = 5'd16,
        OP_LB    = 5'd17,
        OP_LBU   = 5'd18,
        OP_LH    = 5'd19,
        OP_LHU   = 5'd20,
        OP_LW    = 5'd21
    } iexu_op_e;

    typedef struct packed {
        logic             vld;
        logic [XLEN-1:0]  res;
        logic             ovf;
        logic             wen;
        logic [IDX_W-1:0] dst;
    } iexu_out_t;

    function automatic logic is_load(iexu_op_e o);
        return (o == OP_LB) || (o == OP_LBU) || (o == OP_LH) ||
               (o == OP_LHU) || (o == OP_LW);
    endfunction
endpackage

// File: rtl/iexu_imm_ext.sv
module iexu_imm_ext
    import iexu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int IW = IMM_W
) (
    input  iexu_op_e      op,
    input  logic [IW-1:0] imm,
    output logic [W-1:0]  imm_x
);
    localparam int PAD = W - IW;

    always_comb begin
        unique case (op)
            OP_ANDI, OP_ORI, OP_XORI: imm_x = {{PAD{1'b0}}, imm};
            OP_LUI:                   imm_x = {imm, {PAD{1'b0}}};
            default:                  imm_x = {{PAD{imm[IW-1]}}, imm};
        endcase
    end
endmodule

// File: rtl/iexu_alu.sv
module iexu_alu
    import iexu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  iexu_op_e     op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb_reg,
    input  logic [W-1:0] imm_x,
    output logic [W-1:0] res,
    output logic         ovf
);
    localparam int SW = $clog2(W);

    logic         use_imm;
    logic         do_sub;
    logic         chk_ovf;
    logic [W-1:0] opb;
    logic [W-1:0] addend;
    logic [W-1:0] sum;
    logic [SW-1:0] shamt;

    always_comb begin
        use_imm = (op == OP_ADDI) || (op == OP_ADDIU) || (op == OP_ANDI) ||
                  (op == OP_ORI)  || (op == OP_XORI)  || (op == OP_LUI);
        do_sub  = (op == OP_SUB) || (op == OP_SUBU);
        chk_ovf = (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADDI);
        opb     = use_imm ? imm_x : opb_reg;
        addend  = do_sub ? ~opb : opb;
        sum     = opa + addend + {{(W-1){1'b0}}, do_sub};
        shamt   = imm_x[SW-1:0];
        ovf     = chk_ovf && (opa[W-1] == addend[W-1]) && (sum[W-1] != opa[W-1]);

        unique case (op)
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU,
            OP_ADDI, OP_ADDIU:  res = sum;
            OP_AND, OP_ANDI:    res = opa & opb;
            OP_OR, OP_ORI:      res = opa | opb;
            OP_XOR, OP_XORI:    res = opa ^ opb;
            OP_NOR:             res = ~(opa | opb);
            OP_LUI:             res = imm_x;
            OP_SLL:             res = opa << shamt;
            OP_SRL:             res = opa >> shamt;
            OP_SRA:             res = W'($signed(opa) >>> shamt);
            default:            res = '0;
        endcase
    end
endmodule

// File: rtl/iexu_load_ext.sv
module iexu_load_ext
    import iexu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int LW = LANE_W
) (
    input  iexu_op_e      op,
    input  logic [W-1:0]  word,
    input  logic [LW-1:0] addr,
    output logic [W-1:0]  value
);
    localparam int HW = W / 2;

    logic [7:0]    byte_l;
    logic [HW-1:0] half_l;

    always_comb begin
        byte_l = word[{addr, 3'b000} +: 8];
        half_l = addr[LW-1] ? word[W-1:HW] : word[HW-1:0];
        unique case (op)
            OP_LB:   value = {{(W-8){byte_l[7]}}, byte_l};
            OP_LBU:  value = {{(W-8){1'b0}}, byte_l};
            OP_LH:   value = {{(W-HW){half_l[HW-1]}}, half_l};
            OP_LHU:  value = {{(W-HW){1'b0}}, half_l};
            default: value = word;
        endcase
    end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import iexu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic [IDX_W-1:0]  rs_idx,
    input  logic [IDX_W-1:0]  rt_idx,
    input  logic [XLEN-1:0]   src_a,
    input  logic [XLEN-1:0]   src_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic [IDX_W-1:0]  dest_idx,
    input  logic [XLEN-1:0]   ld_word,
    input  logic [LANE_W-1:0] ld_addr,
    output logic              out_valid,
    output logic [XLEN-1:0]   result,
    output logic              ovf_trap,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_dest
);
    iexu_op_e       op_e;
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] imm_x;
    logic [XLEN-1:0] alu_res;
    logic            alu_ovf;
    logic [XLEN-1:0] ld_val;
    iexu_out_t       out_d;
    iexu_out_t       out_q;

    assign op_e = iexu_op_e'(op);
    assign opa  = (rs_idx == '0) ? '0 : src_a;
    assign opb  = (rt_idx == '0) ? '0 : src_b;

    iexu_imm_ext u_imm (
        .op    (op_e),
        .imm   (imm),
        .imm_x (imm_x)
    );

    iexu_alu u_alu (
        .op      (op_e),
        .opa     (opa),
        .opb_reg (opb),
        .imm_x   (imm_x),
        .res     (alu_res),
        .ovf     (alu_ovf)
    );

    iexu_load_ext u_ldx (
        .op    (op_e),
        .word  (ld_word),
        .addr  (ld_addr),
        .value (ld_val)
    );

    always_comb begin
        out_d = '0;
        if (in_valid) begin
            out_d.vld = 1'b1;
            out_d.res = is_load(op_e) ? ld_val : alu_res;
            out_d.ovf = alu_ovf;
            out_d.wen = !alu_ovf && (dest_idx != '0);
            out_d.dst = dest_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid = out_q.vld;
    assign result    = out_q.res;
    assign ovf_trap  = out_q.ovf;
    assign wr_en     = out_q.wen;
    assign wr_dest   = out_q.dst;
endmodule

// File: rtl/int_exec_unit_checker.sv
module int_exec_unit_checker
    import iexu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OP_W-1:0]   op,
    input logic [IDX_W-1:0]  dest_idx,
    input logic              out_valid,
    input logic [XLEN-1:0]   result,
    input logic              ovf_trap,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_dest
);
    logic quiet_op;
    assign quiet_op = (op != OP_ADD) && (op != OP_SUB) && (op != OP_ADDI);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && quiet_op) |=> !ovf_trap);

    a_r5_trap_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> !wr_en);

    a_r8_no_write_r0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dest_idx == '0) |=> !wr_en);

    a_r7_lui_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_LUI) |=> (result[15:0] == 16'h0000));

    a_r6_lbu_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_LBU) |=> (result[XLEN-1:8] == '0));

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!wr_en && !ovf_trap && result == '0 && wr_dest == '0));

    a_r10_dest_capture: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (wr_dest == $past(dest_idx)));
endmodule

bind int_exec_unit int_exec_unit_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .dest_idx  (dest_idx),
    .out_valid (out_valid),
    .result    (result),
    .ovf_trap  (ovf_trap),
    .wr_en     (wr_en),
    .wr_dest   (wr_dest)
);

// File: tb/int_exec_unit_bench.sv
`timescale 1ns/1ps
module int_exec_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op = '0;
    logic [4:0]  rs_idx = '0;
    logic [4:0]  rt_idx = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [15:0] imm = '0;
    logic [4:0]  dest_idx = '0;
    logic [31:0] ld_word = '0;
    logic [1:0]  ld_addr = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        ovf_trap;
    logic        wr_en;
    logic [4:0]  wr_dest;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    int_exec_unit u_int_exec_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .rs_idx(rs_idx), .rt_idx(rt_idx), .src_a(src_a), .src_b(src_b),
        .imm(imm), .dest_idx(dest_idx), .ld_word(ld_word), .ld_addr(ld_addr),
        .out_valid(out_valid), .result(result), .ovf_trap(ovf_trap),
        .wr_en(wr_en), .wr_dest(wr_dest)
    );

    function automatic string res_tag(int o);
        if (o >= 10 && o <= 12) return "R1";
        if (o == 8 || o == 9)   return "R2";
        if (o == 13)            return "R7";
        if (o >= 17 && o <= 21) return "R6";
        if (o == 0 || o == 2)   return "R4";
        return "R9";
    endfunction

    task automatic check(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // behavioural reference for one operation
    task automatic model(input int o, input logic [31:0] a_in, input logic [31:0] b_in,
                         input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] im,
                         input logic [31:0] w, input logic [1:0] ad,
                         output logic [31:0] r, output bit ov);
        longint sa, sb, si, full;
        logic [31:0] a, b, lane;
        int sh;
        a  = (rs == 0) ? 32'h0 : a_in;
        b  = (rt == 0) ? 32'h0 : b_in;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        si = longint'($signed(im));
        sh = int'(im[4:0]);
        ov = 0;
        r  = 32'h0;
        case (o)
            0:  begin full = sa + sb; r = a + b; ov = (full > 64'sd2147483647) || (full < -64'sd2147483648); end
            1:  r = a + b;
            2:  begin full = sa - sb; r = a - b; ov = (full > 64'sd2147483647) || (full < -64'sd2147483648); end
            3:  r = a - b;
            4:  r = a & b;
            5:  r = a | b;
            6:  r = a ^ b;
            7:  r = ~(a | b);
            8:  begin full = sa + si; r = 32'(sa + si); ov = (full > 64'sd2147483647) || (full < -64'sd2147483648); end
            9:  r = 32'(sa + si);
            10: r = a & (32'h0 + im);
            11: r = a | (32'h0 + im);
            12: r = a ^ (32'h0 + im);
            13: r = 32'(im) * 32'd65536;
            14: r = 32'(longint'(a) * (64'd1 << sh));
            15: r = 32'(longint'(a) / (64'd1 << sh));
            16: r = 32'(sa >>> sh);
            17, 18: begin
                lane = (w / (32'd1 << (8 * int'(ad)))) % 32'd256;
                r = (o == 17 && lane >= 128) ? lane - 32'd256 : lane;
            end
            19, 20: begin
                lane = ad[1] ? w / 32'd65536 : w % 32'd65536;
                r = (o == 19 && lane >= 32768) ? lane - 32'd65536 : lane;
            end
            21: r = w;
            default: r = 32'h0;
        endcase
    endtask

    // drive at negedge, compare one cycle later at the next negedge
    task automatic step(input bit v, input int o, input logic [31:0] a, input logic [31:0] b,
                        input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] im,
                        input logic [4:0] rd, input logic [31:0] w, input logic [1:0] ad);
        logic [31:0] er;
        bit eo;
        bit ew;
        in_valid = v; op = 5'(o); src_a = a; src_b = b; rs_idx = rs; rt_idx = rt;
        imm = im; dest_idx = rd; ld_word = w; ld_addr = ad;
        model(o, a, b, rs, rt, im, w, ad, er, eo);
        ew = v && !eo && (rd != 0);
        if (!v) begin er = 0; eo = 0; end
        @(negedge clk);
        check("R10", "out_valid", longint'(out_valid), longint'(v));
        check(v ? res_tag(o) : "R10", "result", longint'(result), longint'(er));
        check((o == 0 || o == 2 || o == 8) ? "R4" : "R3", "ovf_trap", longint'(ovf_trap), longint'(eo));
        check(rd == 0 ? "R8" : (eo ? "R5" : "R10"), "wr_en", longint'(wr_en), longint'(ew));
        check("R10", "wr_dest", longint'(wr_dest), v ? longint'(rd) : 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "out_valid", longint'(out_valid), 0);
        check("R11", "result", longint'(result), 0);
        check("R11", "ovf_trap", longint'(ovf_trap), 0);
        check("R11", "wr_en", longint'(wr_en), 0);
        check("R11", "wr_dest", longint'(wr_dest), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4/R5 signed overflow and write suppression; R3 unsigned forms quiet
        step(1, 0, 32'h7fffffff, 32'h1, 1, 2, 0, 3, 0, 0);
        step(1, 0, 32'h7fffffff, 32'h1, 1, 2, 0, 0, 0, 0);       // trap + r0 together (R8)
        step(1, 0, 32'h80000000, 32'h80000000, 1, 2, 0, 4, 0, 0);
        step(1, 0, 32'hfffffffe, 32'h1, 1, 2, 0, 4, 0, 0);
        step(1, 1, 32'h7fffffff, 32'h1, 1, 2, 0, 5, 0, 0);
        step(1, 2, 32'h80000000, 32'h1, 1, 2, 0, 6, 0, 0);
        step(1, 2, 32'h7fffffff, 32'hffffffff, 1, 2, 0, 6, 0, 0);
        step(1, 2, 32'h5, 32'h3, 1, 2, 0, 6, 0, 0);
        step(1, 3, 32'h0, 32'h1, 1, 2, 0, 7, 0, 0);
        // R2 arithmetic immediates
        step(1, 8, 32'h7fffffff, 0, 1, 0, 16'h0001, 8, 0, 0);
        step(1, 8, 32'h80000000, 0, 1, 0, 16'hffff, 8, 0, 0);
        step(1, 8, 32'h10, 0, 1, 0, 16'h8000, 8, 0, 0);
        step(1, 9, 32'ha, 0, 1, 0, 16'hfffe, 9, 0, 0);
        step(1, 9, 32'h7fffffff, 0, 1, 0, 16'h0001, 9, 0, 0);
        // R1 logical immediates
        step(1, 10, 32'hffffffff, 0, 1, 0, 16'h8000, 10, 0, 0);
        step(1, 11, 32'h0, 0, 1, 0, 16'hffff, 10, 0, 0);
        step(1, 12, 32'hffff0000, 0, 1, 0, 16'hffff, 10, 0, 0);
        // R7 LUI
        step(1, 13, 32'h12345678, 0, 1, 0, 16'habcd, 11, 0, 0);
        step(1, 13, 32'hffffffff, 0, 1, 0, 16'h0000, 11, 0, 0);
        // R9 register-register and shifts
        step(1, 4, 32'hf0f0f0f0, 32'hff00ff00, 1, 2, 0, 12, 0, 0);
        step(1, 5, 32'hf0f0f0f0, 32'h0f0f0f0f, 1, 2, 0, 12, 0, 0);
        step(1, 6, 32'haaaaaaaa, 32'hffffffff, 1, 2, 0, 12, 0, 0);
        step(1, 7, 32'h0, 32'h0, 1, 2, 0, 12, 0, 0);
        step(1, 14, 32'h1, 0, 1, 0, 16'd31, 13, 0, 0);
        step(1, 15, 32'h80000000, 0, 1, 0, 16'd4, 13, 0, 0);
        step(1, 16, 32'h80000000, 0, 1, 0, 16'd4, 13, 0, 0);
        step(1, 16, 32'h40000000, 0, 1, 0, 16'd0, 13, 0, 0);
        // R6 loads, every lane
        for (int ad = 0; ad < 4; ad++) begin
            step(1, 17, 0, 0, 1, 0, 0, 14, 32'h80ff7f01, 2'(ad));
            step(1, 18, 0, 0, 1, 0, 0, 14, 32'h80ff7f01, 2'(ad));
            step(1, 19, 0, 0, 1, 0, 0, 14, 32'h80017fff, 2'(ad));
            step(1, 20, 0, 0, 1, 0, 0, 14, 32'h80017fff, 2'(ad));
        end
        step(1, 21, 0, 0, 1, 0, 0, 14, 32'hdeadbeef, 0);
        // R8 read-as-zero sources, including with an immediate op
        step(1, 1, 32'h11111111, 32'h22222222, 0, 2, 0, 15, 0, 0);
        step(1, 1, 32'h11111111, 32'h22222222, 1, 0, 0, 15, 0, 0);
        step(1, 11, 32'hffffffff, 0, 0, 0, 16'h00ff, 15, 0, 0);
        step(1, 0, 32'h7fffffff, 32'h7fffffff, 0, 2, 0, 15, 0, 0);
        // R10 idle cycles
        step(0, 0, 32'h7fffffff, 32'h1, 1, 2, 0, 3, 0, 0);
        step(0, 13, 0, 0, 0, 0, 16'hffff, 31, 0, 0);
        // mixed pseudo-random traffic
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 8) != 0, int'($urandom % 22), $urandom, $urandom,
                 5'($urandom), 5'($urandom), 16'($urandom), 5'($urandom),
                 $urandom, 2'($urandom));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule